// File: doc/BRIEF.md
# Fuse Word Controller with Shadow Registers

This block fronts a one-time-programmable fuse store of 96 words, 32 bits each, and keeps a bus-visible shadow register for every word. Software reads and writes the shadows directly over a simple 32-bit memory-mapped bus. It reaches the fuses only through a command register. A reload command copies one fuse word into its shadow. A program command burns the contents of the program-data register into one fuse word. The fuse store is a behavioural array inside the block.

Every fuse operation depends on fuse power. A configuration bit requests power, and a status flag reports it only after a settling delay. Each command keeps the block busy for a fixed number of cycles. Three sticky per-word lock maps and one global program lock block accesses without raising any bus error. A reload lock forces a zero load. A shadow-write lock drops bus writes to the shadow. A program lock, or the global lock, leaves the fuses untouched and raises the failure flag. Two sticky per-word maps record reloads attempted without power and programs that were refused.

Top module: `otp_shadow_ctrl`

## Requirements
- R1: After reset, every shadow, every fuse word, every bitmap, the configuration register, the global lock and the status register read as zero.
- R2: Status bit 5 (power good) follows configuration bit 0 (power request) in both directions, and changes only after the request has stayed at its new value for PWR_SETTLE cycles.
- R3: A write to the command register at 0x004 starts an operation on the word indexed by data bits [6:0]. Bit 8 set selects program and bit 8 clear selects reload. Status bit 3 (busy) is set for BUSY_CYCLES cycles. A command written while busy is ignored.
- R4: A completed reload, with power good and no reload lock, copies the fuse word into the shadow at 0x200 + 4*index.
- R5: A completed program ORs the program-data value (register 0x008, captured when the command starts) into the fuse word, clears status bit 4 (fail) and leaves the shadow unchanged.
- R6: A program command leaves the fuses unchanged and sets status bit 4 in three cases: power is down, the word's program-lock bit is set, or global lock bit 4 (register 0x010) is set. The word's bit in the error map is then set as well.
- R7: A reload of a word whose reload-lock bit is set loads zero into its shadow.
- R8: A bus write to a shadow register lands unless that word's shadow-write-lock bit is set, in which case the shadow keeps its value.
- R9: Each per-word map spans three registers 4 bytes apart, with the register chosen by index>>5 and the bit by index[4:0]. The maps sit at these bases: error 0x034, disturbed 0x01C, program lock 0x064, shadow-write lock 0x07C, reload lock 0x094. Lock bits and global lock bit 4 are set by writing 1, are not cleared by writing 0, and clear only on reset.
- R10: A reload with power down leaves the shadow unchanged and sets the word's bit in the disturbed map.
- R11: A command whose index is 96 or above changes no fuse or shadow and sets status bit 4.
- R12: A read returns its data with bus_rvalid high in the cycle after the request. An address that maps to no register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus request valid for one cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |

## Verification
The assertions assume that reset is held for at least two cycles. They also assume that a bus request lasts one cycle and carries a word-aligned address. The bench drives every access through two tasks that hold bus_sel for exactly one clock and release it at the following falling edge, so requests never overlap. The checks on lock and power-flag history rely on the lock inputs and the power request not changing while an operation is in flight. The bench therefore waits for busy to clear before it touches any lock, the power request or the global lock.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int unsigned REG_AW = 12;
    localparam int unsigned BUS_DW = 32;

    localparam logic [REG_AW-1:0] OFS_CFG    = 12'h000;
    localparam logic [REG_AW-1:0] OFS_CMD    = 12'h004;
    localparam logic [REG_AW-1:0] OFS_PDATA  = 12'h008;
    localparam logic [REG_AW-1:0] OFS_STAT   = 12'h00C;
    localparam logic [REG_AW-1:0] OFS_GLOCK  = 12'h010;
    localparam logic [REG_AW-1:0] OFS_DIST   = 12'h01C;
    localparam logic [REG_AW-1:0] OFS_ERR    = 12'h034;
    localparam logic [REG_AW-1:0] OFS_PLOCK  = 12'h064;
    localparam logic [REG_AW-1:0] OFS_WLOCK  = 12'h07C;
    localparam logic [REG_AW-1:0] OFS_RLOCK  = 12'h094;
    localparam logic [REG_AW-1:0] OFS_SHADOW = 12'h200;

    localparam int unsigned CFG_PWR_BIT    = 0;
    localparam int unsigned CMD_OP_BIT     = 8;
    localparam int unsigned STAT_BUSY_BIT  = 3;
    localparam int unsigned STAT_FAIL_BIT  = 4;
    localparam int unsigned STAT_PWR_BIT   = 5;
    localparam int unsigned GLOCK_PROG_BIT = 4;

    typedef enum logic {
        OP_RELOAD  = 1'b0,
        OP_PROGRAM = 1'b1
    } otp_op_e;

    typedef struct packed {
        logic pwr;
        logic fail;
        logic busy;
    } otp_stat_t;

    function automatic int unsigned banks_for(int unsigned nbits);
        return (nbits + 31) / 32;
    endfunction

    function automatic logic [BUS_DW-1:0] pack_status(otp_stat_t s);
        logic [BUS_DW-1:0] v;
        v = '0;
        v[STAT_BUSY_BIT] = s.busy;
        v[STAT_FAIL_BIT] = s.fail;
        v[STAT_PWR_BIT]  = s.pwr;
        return v;
    endfunction

endpackage

// File: rtl/otp_power_seq.sv
module otp_power_seq #(
    parameter int unsigned SETTLE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic ok
);
    localparam int unsigned CW = (SETTLE < 2) ? 1 : $clog2(SETTLE);
    localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE - 1);

    logic [CW-1:0] cnt_q;
    logic          ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ok_q  <= 1'b0;
        end else if (req != ok_q) begin
            if (cnt_q == CNT_LAST) begin
                ok_q  <= req;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign ok = ok_q;
endmodule

// File: rtl/otp_sticky_map.sv
module otp_sticky_map
    import otp_pkg::*;
#(
    parameter int unsigned       NBITS   = 96,
    parameter logic [REG_AW-1:0] BASE    = '0,
    parameter bit                BUS_SET = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic [NBITS-1:0]  set_vec,
    output logic [NBITS-1:0]  bits,
    output logic [BUS_DW-1:0] rd_data
);
    localparam int unsigned NBANK = banks_for(NBITS);
    localparam int unsigned PADW  = NBANK * 32;

    logic [PADW-1:0]               set_pad;
    logic [PADW-1:0]               map_flat;
    logic [NBANK-1:0][BUS_DW-1:0]  rd_part;

    assign set_pad = PADW'(set_vec);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int unsigned VALID = ((NBITS - 32*b) >= 32) ? 32 : (NBITS - 32*b);
        localparam logic [31:0] MASK  = (VALID == 32) ? 32'hFFFF_FFFF
                                                      : ((32'd1 << VALID) - 32'd1);
        localparam logic [REG_AW-1:0] BANK_ADDR = BASE + REG_AW'(4*b);

        logic        hit;
        logic [31:0] bank_q;

        assign hit = (bus_addr == BANK_ADDR);

        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q <= '0;
            end else begin
                bank_q <= (bank_q | set_pad[32*b +: 32]
                           | ((BUS_SET && bus_wr && hit) ? bus_wdata : 32'h0)) & MASK;
            end
        end

        assign map_flat[32*b +: 32] = bank_q;
        assign rd_part[b]           = hit ? bank_q : 32'h0;
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NBANK; b++) begin
            rd_data = rd_data | rd_part[b];
        end
    end

    assign bits = map_flat[NBITS-1:0];
endmodule

// File: rtl/otp_fuse_engine.sv
module otp_fuse_engine
    import otp_pkg::*;
#(
    parameter int unsigned NWORDS      = 96,
    parameter int unsigned BUSY_CYCLES = 8,
    parameter int unsigned IDX_W       = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  otp_op_e           start_op,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [BUS_DW-1:0] start_data,
    input  logic              pwr_ok,
    input  logic [NWORDS-1:0] plock,
    input  logic              glock,
    input  logic [NWORDS-1:0] rlock,
    output logic              busy,
    output logic              fail,
    output logic              sh_load,
    output logic [IDX_W-1:0]  sh_idx,
    output logic [BUS_DW-1:0] sh_data,
    output logic [NWORDS-1:0] err_set,
    output logic [NWORDS-1:0] dist_set
);
    localparam int unsigned CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0]  cnt_q;
    otp_op_e           op_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BUS_DW-1:0] data_q;
    logic              busy_q;
    logic              fail_q;
    logic [BUS_DW-1:0] fuse_q [NWORDS];

    logic             in_range;
    logic             done;
    logic             prog_block;
    logic [IDX_W-1:0] idx_safe;

    assign in_range   = ({1'b0, idx_q} < (IDX_W+1)'(NWORDS));
    assign idx_safe   = in_range ? idx_q : '0;
    assign done       = busy_q && (cnt_q == CNT_LAST);
    assign prog_block = !in_range || !pwr_ok || glock || plock[idx_safe];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            fail_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_RELOAD;
            idx_q  <= '0;
            data_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                fail_q <= 1'b0;
                cnt_q  <= '0;
                op_q   <= start_op;
                idx_q  <= start_idx;
                data_q <= start_data;
            end
        end else if (done) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            if (op_q == OP_PROGRAM) begin
                fail_q <= prog_block;
            end else if (!in_range) begin
                fail_q <= 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) begin
                fuse_q[i] <= '0;
            end
        end else if (done && (op_q == OP_PROGRAM) && !prog_block) begin
            fuse_q[idx_safe] <= fuse_q[idx_safe] | data_q;
        end
    end

    assign sh_load = done && (op_q == OP_RELOAD) && in_range && pwr_ok;
    assign sh_idx  = idx_safe;
    assign sh_data = rlock[idx_safe] ? '0 : fuse_q[idx_safe];

    always_comb begin
        err_set  = '0;
        dist_set = '0;
        if (done && in_range) begin
            if ((op_q == OP_PROGRAM) && prog_block) begin
                err_set[idx_safe] = 1'b1;
            end
            if ((op_q == OP_RELOAD) && !pwr_ok) begin
                dist_set[idx_safe] = 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign fail = fail_q;
endmodule

// File: rtl/otp_shadow_ctrl.sv
module otp_shadow_ctrl
    import otp_pkg::*;
#(
    parameter int unsigned NWORDS      = 96,
    parameter int unsigned BUSY_CYCLES = 8,
    parameter int unsigned PWR_SETTLE  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        bus_rvalid,
    output logic [31:0] bus_rdata
);
    localparam int unsigned IDX_W = $clog2(NWORDS);

    logic bus_wr;
    assign bus_wr = bus_sel && bus_we;

    logic              cfg_pwr_q;
    logic [BUS_DW-1:0] pdata_q;
    logic [8:0]        cmd_q;
    logic              glock_q;
    logic              cmd_wr;

    logic              pwr_ok_w;
    logic              busy_w;
    logic              fail_w;
    logic              sh_load;
    logic [IDX_W-1:0]  sh_idx;
    logic [BUS_DW-1:0] sh_data;
    logic [NWORDS-1:0] err_set;
    logic [NWORDS-1:0] dist_set;
    logic [NWORDS-1:0] plock_w;
    logic [NWORDS-1:0] wlock_w;
    logic [NWORDS-1:0] rlock_w;
    logic [NWORDS-1:0] err_w;
    logic [NWORDS-1:0] dist_w;
    logic [BUS_DW-1:0] rd_err, rd_dist, rd_plock, rd_wlock, rd_rlock;

    assign cmd_wr = bus_wr && (bus_addr == OFS_CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_pwr_q <= 1'b0;
            pdata_q   <= '0;
            cmd_q     <= '0;
            glock_q   <= 1'b0;
        end else begin
            if (bus_wr && (bus_addr == OFS_CFG)) begin
                cfg_pwr_q <= bus_wdata[CFG_PWR_BIT];
            end
            if (bus_wr && (bus_addr == OFS_PDATA)) begin
                pdata_q <= bus_wdata;
            end
            if (cmd_wr && !busy_w) begin
                cmd_q <= bus_wdata[8:0];
            end
            if (bus_wr && (bus_addr == OFS_GLOCK) && bus_wdata[GLOCK_PROG_BIT]) begin
                glock_q <= 1'b1;
            end
        end
    end

    otp_power_seq #(.SETTLE(PWR_SETTLE)) u_pwr (
        .clk (clk),
        .rst (rst),
        .req (cfg_pwr_q),
        .ok  (pwr_ok_w)
    );

    otp_fuse_engine #(
        .NWORDS      (NWORDS),
        .BUSY_CYCLES (BUSY_CYCLES),
        .IDX_W       (IDX_W)
    ) u_eng (
        .clk        (clk),
        .rst        (rst),
        .start      (cmd_wr),
        .start_op   (otp_op_e'(bus_wdata[CMD_OP_BIT])),
        .start_idx  (bus_wdata[IDX_W-1:0]),
        .start_data (pdata_q),
        .pwr_ok     (pwr_ok_w),
        .plock      (plock_w),
        .glock      (glock_q),
        .rlock      (rlock_w),
        .busy       (busy_w),
        .fail       (fail_w),
        .sh_load    (sh_load),
        .sh_idx     (sh_idx),
        .sh_data    (sh_data),
        .err_set    (err_set),
        .dist_set   (dist_set)
    );

    otp_sticky_map #(.NBITS(NWORDS), .BASE(OFS_PLOCK), .BUS_SET(1'b1)) u_plock (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .set_vec('0), .bits(plock_w), .rd_data(rd_plock)
    );
    otp_sticky_map #(.NBITS(NWORDS), .BASE(OFS_WLOCK), .BUS_SET(1'b1)) u_wlock (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .set_vec('0), .bits(wlock_w), .rd_data(rd_wlock)
    );
    otp_sticky_map #(.NBITS(NWORDS), .BASE(OFS_RLOCK), .BUS_SET(1'b1)) u_rlock (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .set_vec('0), .bits(rlock_w), .rd_data(rd_rlock)
    );
    otp_sticky_map #(.NBITS(NWORDS), .BASE(OFS_ERR), .BUS_SET(1'b0)) u_err (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .set_vec(err_set), .bits(err_w), .rd_data(rd_err)
    );
    otp_sticky_map #(.NBITS(NWORDS), .BASE(OFS_DIST), .BUS_SET(1'b0)) u_dist (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .set_vec(dist_set), .bits(dist_w), .rd_data(rd_dist)
    );

    // Shadow window decode
    logic [REG_AW-1:0] sh_off;
    logic              sh_hit;
    logic [IDX_W-1:0]  sh_widx;
    logic [BUS_DW-1:0] shadow_q [NWORDS];

    assign sh_off  = bus_addr - OFS_SHADOW;
    assign sh_hit  = (bus_addr >= OFS_SHADOW) && (sh_off[1:0] == 2'b00)
                     && (sh_off[REG_AW-1:2] < (REG_AW-2)'(NWORDS));
    assign sh_widx = sh_off[IDX_W+1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) begin
                shadow_q[i] <= '0;
            end
        end else begin
            if (bus_wr && sh_hit && !wlock_w[sh_widx]) begin
                shadow_q[sh_widx] <= bus_wdata;
            end
            if (sh_load) begin
                shadow_q[sh_idx] <= sh_data;
            end
        end
    end

    // Read path
    logic [BUS_DW-1:0] rd_mux;
    otp_stat_t         stat_w;

    assign stat_w = '{pwr: pwr_ok_w, fail: fail_w, busy: busy_w};

    always_comb begin
        rd_mux = rd_err | rd_dist | rd_plock | rd_wlock | rd_rlock;
        if (sh_hit) begin
            rd_mux = shadow_q[sh_widx];
        end
        case (bus_addr)
            OFS_CFG:   rd_mux = BUS_DW'(cfg_pwr_q);
            OFS_CMD:   rd_mux = BUS_DW'(cmd_q);
            OFS_PDATA: rd_mux = pdata_q;
            OFS_STAT:  rd_mux = pack_status(stat_w);
            OFS_GLOCK: rd_mux = BUS_DW'(glock_q) << GLOCK_PROG_BIT;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_sel && !bus_we;
            if (bus_sel && !bus_we) begin
                bus_rdata <= rd_mux;
            end
        end
    end
endmodule

// File: rtl/otp_shadow_ctrl_chk.sv
module otp_shadow_ctrl_chk #(
    parameter int unsigned NWORDS = 96
) (
    input logic                clk,
    input logic                rst,
    input logic                busy,
    input logic                fail,
    input logic                pwr_ok,
    input logic                pwr_req,
    input logic                cmd_wr,
    input logic [8:0]          cmd_q,
    input logic [3*NWORDS-1:0] locks
);
    // R3: a command arriving while busy does not replace the running one
    assert_cmd_held_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr) |=> $stable(cmd_q));

    // R3: a command arriving while idle makes the block busy
    assert_busy_start_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_wr) |=> busy);

    // R2: power good rises only after a request, and falls only after it is withdrawn
    assert_pwr_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_ok) |-> $past(pwr_req));
    assert_pwr_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_ok) |-> !$past(pwr_req));

    // R6: the failure flag is raised only as an operation completes
    assert_fail_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> $fell(busy));

    // R9: lock bits never clear outside reset
    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((locks & $past(locks)) == $past(locks)));
endmodule

bind otp_shadow_ctrl otp_shadow_ctrl_chk #(.NWORDS(NWORDS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy_w),
    .fail    (fail_w),
    .pwr_ok  (pwr_ok_w),
    .pwr_req (cfg_pwr_q),
    .cmd_wr  (cmd_wr),
    .cmd_q   (cmd_q),
    .locks   ({plock_w, wlock_w, rlock_w})
);

// File: tb/sim_otp_shadow_ctrl.sv
`timescale 1ns/1ps
module sim_otp_shadow_ctrl;
    localparam int BUSY_CYCLES = 8;
    localparam int PWR_SETTLE  = 4;
    localparam int NVEC        = 8;

    localparam int          VEC_IDX [NVEC] = '{0, 1, 31, 32, 63, 64, 94, 95};
    localparam logic [31:0] VEC_DAT [NVEC] = '{32'h1111_0001, 32'h2222_0002, 32'h8000_0031,
                                               32'h0000_3232, 32'hFFFF_FFFF, 32'h6464_6464,
                                               32'h9494_0000, 32'h0095_0095};

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    otp_shadow_ctrl #(.NWORDS(96), .BUSY_CYCLES(BUSY_CYCLES), .PWR_SETTLE(PWR_SETTLE)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
    );

    function automatic logic [11:0] sh_addr(int i);
        return 12'h200 + 12'(i * 4);
    endfunction

    task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        if (bus_rvalid !== 1'b1) begin
            n_run++; n_fail++;
            $display("FAIL R12 rvalid: got %b expected 1", bus_rvalid);
        end
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 200; k++) begin
            bus_read(12'h00C, s);
            if (!s[3]) break;
        end
    endtask

    task automatic issue(input bit prog, input int idx, input logic [31:0] d);
        if (prog) bus_write(12'h008, d);
        bus_write(12'h004, (prog ? 32'h100 : 32'h0) | 32'(idx));
        wait_idle();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL R3 watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        bus_read(12'h00C, v); expect_eq("R1 status", v, 32'h0);
        bus_read(12'h000, v); expect_eq("R1 config", v, 32'h0);
        bus_read(sh_addr(5), v); expect_eq("R1 shadow5", v, 32'h0);
        bus_read(12'h064, v); expect_eq("R1 program lock", v, 32'h0);
        bus_read(12'h010, v); expect_eq("R1 global lock", v, 32'h0);

        // R8: vector table of unlocked shadow writes and read-back
        for (int i = 0; i < NVEC; i++) bus_write(sh_addr(VEC_IDX[i]), VEC_DAT[i]);
        for (int i = 0; i < NVEC; i++) begin
            bus_read(sh_addr(VEC_IDX[i]), v);
            expect_eq("R8 shadow table", v, VEC_DAT[i]);
        end

        // R2: power-up handshake
        bus_write(12'h000, 32'h1);
        bus_read(12'h00C, v); expect_eq("R2 power not yet good", v & 32'h20, 32'h0);
        repeat (3 * PWR_SETTLE) @(negedge clk);
        bus_read(12'h00C, v); expect_eq("R2 power good", v & 32'h20, 32'h20);

        // R3 R5 R4: program, shadow untouched, reload
        bus_write(12'h008, 32'hA5A5_0000);
        bus_write(12'h004, 32'h107);
        bus_read(12'h00C, v); expect_eq("R3 busy set", v & 32'h8, 32'h8);
        repeat (BUSY_CYCLES + 2) @(negedge clk);
        bus_read(12'h00C, v); expect_eq("R3 busy cleared", v & 32'h18, 32'h0);
        bus_read(sh_addr(7), v); expect_eq("R5 shadow unchanged by program", v, 32'h0);
        issue(1'b0, 7, 32'h0);
        bus_read(sh_addr(7), v); expect_eq("R4 reload", v, 32'hA5A5_0000);
        issue(1'b1, 7, 32'h0F00_00FF);
        issue(1'b0, 7, 32'h0);
        bus_read(sh_addr(7), v); expect_eq("R5 OR into fuse", v, 32'hAFA5_00FF);

        // R3: command written while busy is ignored
        bus_write(12'h004, 32'h00A);
        bus_write(12'h008, 32'h7777_7777);
        bus_write(12'h004, 32'h10A);
        wait_idle();
        repeat (BUSY_CYCLES + 2) @(negedge clk);
        issue(1'b0, 10, 32'h0);
        bus_read(sh_addr(10), v); expect_eq("R3 busy command ignored", v, 32'h0);

        // R6 R9: per-word program lock
        bus_write(12'h064, 32'h0000_1000);
        issue(1'b1, 12, 32'h0000_FFFF);
        bus_read(12'h00C, v); expect_eq("R6 fail on locked word", v & 32'h10, 32'h10);
        bus_read(12'h034, v); expect_eq("R6 error map bit12", v, 32'h0000_1000);
        issue(1'b0, 12, 32'h0);
        bus_read(sh_addr(12), v); expect_eq("R6 locked fuse unchanged", v, 32'h0);
        bus_write(12'h064, 32'h0);
        bus_read(12'h064, v); expect_eq("R9 lock sticky", v, 32'h0000_1000);
        bus_write(12'h068, 32'h0000_0100);
        issue(1'b1, 41, 32'h0000_1234);
        bus_read(12'h00C, v); expect_eq("R9 neighbour not locked", v & 32'h10, 32'h0);
        issue(1'b0, 41, 32'h0);
        bus_read(sh_addr(41), v); expect_eq("R9 neighbour programmed", v, 32'h0000_1234);
        issue(1'b1, 40, 32'hFFFF_FFFF);
        bus_read(12'h038, v); expect_eq("R9 error bank1 bit8", v, 32'h0000_0100);

        // R7: reload lock loads zero
        bus_write(12'h094, 32'h0000_0080);
        issue(1'b0, 7, 32'h0);
        bus_read(sh_addr(7), v); expect_eq("R7 reload lock zero", v, 32'h0);

        // R8: shadow write lock
        bus_write(12'h084, 32'h8000_0000);
        bus_write(sh_addr(95), 32'hDEAD_0000);
        bus_read(sh_addr(95), v); expect_eq("R8 locked shadow kept", v, 32'h0095_0095);
        bus_write(sh_addr(94), 32'h0BAD_F00D);
        bus_read(sh_addr(94), v); expect_eq("R8 unlocked shadow written", v, 32'h0BAD_F00D);

        // R2 R10 R6: power down
        bus_write(12'h000, 32'h0);
        repeat (3 * PWR_SETTLE) @(negedge clk);
        bus_read(12'h00C, v); expect_eq("R2 power dropped", v & 32'h20, 32'h0);
        bus_write(sh_addr(50), 32'h5050_5050);
        issue(1'b0, 50, 32'h0);
        bus_read(sh_addr(50), v); expect_eq("R10 shadow kept", v, 32'h5050_5050);
        bus_read(12'h020, v); expect_eq("R10 disturbed bank1 bit18", v, 32'h0004_0000);
        issue(1'b1, 50, 32'h1);
        bus_read(12'h00C, v); expect_eq("R6 fail when unpowered", v & 32'h10, 32'h10);

        // R11: out-of-range index
        bus_write(12'h000, 32'h1);
        repeat (3 * PWR_SETTLE) @(negedge clk);
        issue(1'b0, 100, 32'h0);
        bus_read(12'h00C, v); expect_eq("R11 reload index 100 fails", v & 32'h10, 32'h10);
        issue(1'b1, 100, 32'hFFFF_FFFF);
        bus_read(12'h00C, v); expect_eq("R11 program index 100 fails", v & 32'h10, 32'h10);

        // R6 R9: global program lock
        bus_write(12'h010, 32'h10);
        issue(1'b1, 41, 32'hFFFF_0000);
        bus_read(12'h00C, v); expect_eq("R6 global lock fail", v & 32'h10, 32'h10);
        issue(1'b0, 41, 32'h0);
        bus_read(sh_addr(41), v); expect_eq("R6 global lock fuse unchanged", v, 32'h0000_1234);
        bus_write(12'h010, 32'h0);
        bus_read(12'h010, v); expect_eq("R9 global lock sticky", v, 32'h10);

        // R12: unmapped address
        bus_read(12'h180, v); expect_eq("R12 unmapped zero", v, 32'h0);

        summary();
        $finish;
    end
endmodule